// File: doc/BRIEF.md
# Four-Source Interrupt Controller

This block gathers interrupt requests for a small CPU core from four places: an asynchronous external pin whose active edge is selectable, a one-cycle overflow pulse from an 8-bit timer, a change on the upper four lines of an input port, and a completion pulse from a non-volatile memory write engine. Each source owns a sticky flag and an individual enable. A global enable gates them all. The block drives one request line and a constant vector address (0004h) to the core.

The core signals acceptance of an interrupt with a one-cycle `irq_ack`. That pulse drops the global enable so the handler is not interrupted again. The core signals a return from interrupt with `irq_ret`, which raises the global enable again. Software clears flags through a bit mask. It writes the enables through simple write strobes. A `wake` output tells a sleeping core that some enabled flag is pending. `wake` ignores the global enable, so the core can decide whether to vector or just resume.

For the port-change source, the block keeps a copy of the upper port lines as they were at the last port read. Any input line that differs from its copy sets the change flag. A read reloads the copy and so ends the mismatch.

Top module: `intc_quad`

## Requirements
- R1: A one-cycle `tmr_ovf` pulse sets flag bit 1, and a one-cycle `nvw_done` pulse sets flag bit 3; each flag is visible on `flags` at the clock edge that samples the pulse.
- R2: Flag bit positions are 0 external pin, 1 timer, 2 port change, 3 write completion. A source sets its flag whatever the state of `enables` and `gie`. A flag stays set until software clears it with the matching bit of `flag_clr`. If a hardware set and a clear of the same bit fall in one cycle, the set wins.
- R3: `irq_req` is 1 exactly when some flag bit and the same bit of `enables` are both 1 and `gie` is 1.
- R4: A cycle with `irq_ack` high leaves `gie` at 0 after that edge. `irq_vec` always reads 0004h.
- R5: A cycle with `irq_ret` high and `irq_ack` low leaves `gie` at 1. When `irq_ack` and `irq_ret` are high together, `irq_ack` wins. Both strobes take precedence over a `gie_we` write.
- R6: `ext_pin` passes through a two-flop synchroniser. `edge_rise`=1 selects the rising edge and `edge_rise`=0 selects the falling edge. Flag bit 0 is set at the third clock edge after the pin changes, and the opposite edge leaves the flag at 0.
- R7: Flag bit 2 is set when any line of `port_hi` whose `port_dir` bit is 1 (input) differs from its latched copy. Lines with `port_dir` bit 0 (output) never set it.
- R8: A cycle with `port_rd` high loads the latch from `port_hi`. Once the latch matches, a cleared change flag stays at 0. While a mismatch remains, the flag sets again after every clear.
- R9: Reset (synchronous, active high) clears all flags, all enables and `gie`, and loads the port latch from `port_hi`.
- R10: `wake` is 1 exactly when some flag bit and the same `enables` bit are both 1, regardless of `gie`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | 1 | Asynchronous external request pin |
| edge_rise | input | 1 | 1 selects rising edge, 0 falling edge |
| tmr_ovf | input | 1 | Timer wrap pulse (FFh to 00h) |
| port_hi | input | 4 | Port lines 7..4 |
| port_dir | input | 4 | Per-line direction, 1 = input |
| port_rd | input | 1 | Port read strobe, reloads the latch |
| nvw_done | input | 1 | Non-volatile write completion pulse |
| flag_clr | input | 4 | Software flag clear mask |
| en_we | input | 1 | Enable register write strobe |
| en_wdata | input | 4 | New individual enables |
| gie_we | input | 1 | Global enable write strobe |
| gie_wdata | input | 1 | New global enable value |
| irq_ack | input | 1 | Core accepts the interrupt |
| irq_ret | input | 1 | Core returns from interrupt |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 13 | Fixed vector address |
| wake | output | 1 | Wake-from-sleep request |
| flags | output | 4 | Flag register |
| enables | output | 4 | Individual enable register |
| gie | output | 1 | Global enable |

## Verification
On every cycle, the assertions check the global-enable handshake: acceptance clears it, and a lone return sets it. They also check that a flag never drops without its clear bit, that the timer and write-completion pulses land in their flags, and that a port read with steady pins removes the mismatch. The scenarios must show the rest. These are the synchroniser delay and the edge polarity choice on the pin, the exclusion of output lines from the change compare, the flag re-setting while a mismatch persists, and the set-over-clear and acknowledge-over-return priorities. They also cover the separation of `wake` from `gie`.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int NUM_SRC   = 4;
    localparam int VEC_W     = 13;
    localparam int CHG_W     = 4;
    localparam logic [VEC_W-1:0] IRQ_VECTOR = 13'h0004;

    typedef enum logic [1:0] {
        SRC_EXT = 2'd0,
        SRC_TMR = 2'd1,
        SRC_CHG = 2'd2,
        SRC_NVW = 2'd3
    } src_e;

    typedef struct packed {
        logic ack;
        logic ret;
        logic we;
        logic wdata;
    } gie_ctl_s;

    // Acceptance beats return, both beat a software write.
    function automatic logic gie_next(input logic cur, input gie_ctl_s c);
        if (c.ack)      return 1'b0;
        else if (c.ret) return 1'b1;
        else if (c.we)  return c.wdata;
        else            return cur;
    endfunction

endpackage

// File: rtl/intc_edge_det.sv
module intc_edge_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_async,
    input  logic rise_sel,
    output logic edge_hit
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_async};
            prev_q <= sync_q[LAST];
        end
    end

    always_comb begin
        if (rise_sel) edge_hit = sync_q[LAST] & ~prev_q;
        else          edge_hit = ~sync_q[LAST] & prev_q;
    end

endmodule

// File: rtl/intc_port_chg.sv
module intc_port_chg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pins,
    input  logic [W-1:0] dir_in,
    input  logic         rd,
    output logic         mismatch
);
    logic [W-1:0] latch_q;
    logic [W-1:0] diff;

    always_ff @(posedge clk) begin
        if (rst || rd) latch_q <= pins;
    end

    always_comb begin
        diff     = (pins ^ latch_q) & dir_in;
        mismatch = |diff;
    end

    AST_READ_ENDS_MISMATCH: assert property (@(posedge clk) disable iff (rst)
        rd |=> (pins != $past(pins) || dir_in != $past(dir_in) || !mismatch)); // R8

endmodule

// File: rtl/intc_flag_reg.sv
module intc_flag_reg
    import intc_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    input  logic         en_we,
    input  logic [N-1:0] en_wdata,
    input  gie_ctl_s     gctl,
    output logic [N-1:0] flags_q,
    output logic [N-1:0] en_q,
    output logic         gie_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            gie_q <= 1'b0;
        end else begin
            if (en_we) en_q <= en_wdata;
            gie_q <= gie_next(gie_q, gctl);
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)         flags_q[i] <= 1'b0;
            else if (set[i]) flags_q[i] <= 1'b1;
            else if (clr[i]) flags_q[i] <= 1'b0;
        end

        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
            (flags_q[i] && !clr[i]) |=> flags_q[i]); // R2
    end

    AST_ACK_DROPS_GIE: assert property (@(posedge clk) disable iff (rst)
        gctl.ack |=> !gie_q); // R4

    AST_RET_RAISES_GIE: assert property (@(posedge clk) disable iff (rst)
        (gctl.ret && !gctl.ack) |=> gie_q); // R5

endmodule

// File: rtl/intc_quad.sv
module intc_quad
    import intc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               ext_pin,
    input  logic               edge_rise,
    input  logic               tmr_ovf,
    input  logic [CHG_W-1:0]   port_hi,
    input  logic [CHG_W-1:0]   port_dir,
    input  logic               port_rd,
    input  logic               nvw_done,
    input  logic [NUM_SRC-1:0] flag_clr,
    input  logic               en_we,
    input  logic [NUM_SRC-1:0] en_wdata,
    input  logic               gie_we,
    input  logic               gie_wdata,
    input  logic               irq_ack,
    input  logic               irq_ret,
    output logic               irq_req,
    output logic [VEC_W-1:0]   irq_vec,
    output logic               wake,
    output logic [NUM_SRC-1:0] flags,
    output logic [NUM_SRC-1:0] enables,
    output logic               gie
);
    logic               ext_hit;
    logic               chg_hit;
    logic [NUM_SRC-1:0] set_vec;
    logic [NUM_SRC-1:0] pending;
    gie_ctl_s           gctl;

    intc_edge_det #(.SYNC_STAGES(2)) u_edge (
        .clk      (clk),
        .rst      (rst),
        .pin_async(ext_pin),
        .rise_sel (edge_rise),
        .edge_hit (ext_hit)
    );

    intc_port_chg #(.W(CHG_W)) u_chg (
        .clk     (clk),
        .rst     (rst),
        .pins    (port_hi),
        .dir_in  (port_dir),
        .rd      (port_rd),
        .mismatch(chg_hit)
    );

    always_comb begin
        set_vec          = '0;
        set_vec[SRC_EXT] = ext_hit;
        set_vec[SRC_TMR] = tmr_ovf;
        set_vec[SRC_CHG] = chg_hit;
        set_vec[SRC_NVW] = nvw_done;
        gctl.ack   = irq_ack;
        gctl.ret   = irq_ret;
        gctl.we    = gie_we;
        gctl.wdata = gie_wdata;
    end

    intc_flag_reg #(.N(NUM_SRC)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .set     (set_vec),
        .clr     (flag_clr),
        .en_we   (en_we),
        .en_wdata(en_wdata),
        .gctl    (gctl),
        .flags_q (flags),
        .en_q    (enables),
        .gie_q   (gie)
    );

    always_comb begin
        pending = flags & enables;
        wake    = |pending;
        irq_req = wake & gie;
        irq_vec = IRQ_VECTOR;
    end

    AST_TMR_LANDS: assert property (@(posedge clk) disable iff (rst)
        tmr_ovf |=> flags[SRC_TMR]); // R1

    AST_NVW_LANDS: assert property (@(posedge clk) disable iff (rst)
        nvw_done |=> flags[SRC_NVW]); // R1

endmodule

// File: tb/intc_quad_bench.sv
module intc_quad_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ext_pin = 0, edge_rise = 1, tmr_ovf = 0, port_rd = 0, nvw_done = 0;
    logic [3:0] port_hi = 0, port_dir = 4'hF, flag_clr = 0, en_wdata = 0;
    logic       en_we = 0, gie_we = 0, gie_wdata = 0, irq_ack = 0, irq_ret = 0;
    logic       irq_req, wake, gie;
    logic [12:0] irq_vec;
    logic [3:0] flags, enables;
    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    intc_quad u_intc_quad (
        .clk(clk), .rst(rst), .ext_pin(ext_pin), .edge_rise(edge_rise),
        .tmr_ovf(tmr_ovf), .port_hi(port_hi), .port_dir(port_dir), .port_rd(port_rd),
        .nvw_done(nvw_done), .flag_clr(flag_clr), .en_we(en_we), .en_wdata(en_wdata),
        .gie_we(gie_we), .gie_wdata(gie_wdata), .irq_ack(irq_ack), .irq_ret(irq_ret),
        .irq_req(irq_req), .irq_vec(irq_vec), .wake(wake), .flags(flags),
        .enables(enables), .gie(gie)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic clear_all();
        flag_clr = 4'hF; step(1); flag_clr = 0;
    endtask

    task automatic t_reset();
        chk("R9 flags", flags, 0);
        chk("R9 enables", enables, 0);
        chk("R9 gie", gie, 0);
        chk("R3 req", irq_req, 0);
        chk("R4 vec", irq_vec, 13'h0004);
    endtask

    task automatic t_pulses();
        tmr_ovf = 1; step(1); tmr_ovf = 0;
        chk("R1 timer flag", flags, 4'b0010);
        chk("R10 wake off", wake, 0);
        nvw_done = 1; step(1); nvw_done = 0;
        chk("R1 nvw flag", flags, 4'b1010);
        step(2);
        chk("R2 sticky", flags, 4'b1010);
        clear_all();
        chk("R2 clear", flags, 0);
        tmr_ovf = 1; flag_clr = 4'b0010; step(1); tmr_ovf = 0; flag_clr = 0;
        chk("R2 set wins", flags, 4'b0010);
        clear_all();
    endtask

    task automatic t_handshake();
        en_we = 1; en_wdata = 4'b0010; step(1); en_we = 0;
        tmr_ovf = 1; step(1); tmr_ovf = 0;
        chk("R10 wake without gie", wake, 1);
        chk("R3 no req without gie", irq_req, 0);
        gie_we = 1; gie_wdata = 1; step(1); gie_we = 0;
        chk("R3 req", irq_req, 1);
        irq_ack = 1; step(1); irq_ack = 0;
        chk("R4 ack clears gie", gie, 0);
        chk("R3 req drops", irq_req, 0);
        irq_ret = 1; step(1); irq_ret = 0;
        chk("R5 ret sets gie", gie, 1);
        irq_ack = 1; irq_ret = 1; step(1); irq_ack = 0; irq_ret = 0;
        chk("R5 ack wins", gie, 0);
        irq_ret = 1; gie_we = 1; gie_wdata = 0; step(1); irq_ret = 0; gie_we = 0;
        chk("R5 ret over write", gie, 1);
        clear_all();
        chk("R3 req after clear", irq_req, 0);
        gie_we = 1; gie_wdata = 0; en_we = 1; en_wdata = 0; step(1); gie_we = 0; en_we = 0;
    endtask

    task automatic t_ext();
        edge_rise = 1; ext_pin = 1; step(2);
        chk("R6 not before sync", flags[0], 0);
        step(1);
        chk("R6 rising", flags[0], 1);
        clear_all();
        ext_pin = 0; step(4);
        chk("R6 falling ignored", flags[0], 0);
        edge_rise = 0; ext_pin = 1; step(4);
        chk("R6 rising ignored", flags[0], 0);
        ext_pin = 0; step(3);
        chk("R6 falling", flags[0], 1);
        clear_all();
    endtask

    task automatic t_port();
        port_dir = 4'hF; port_rd = 1; step(1); port_rd = 0;
        clear_all();
        port_hi = 4'b0010; step(1);
        chk("R7 change", flags[2], 1);
        clear_all();
        chk("R8 re-set while mismatch", flags[2], 1);
        port_rd = 1; step(1); port_rd = 0;
        clear_all();
        step(2);
        chk("R8 read ends mismatch", flags[2], 0);
        port_dir = 4'b1110; port_hi = 4'b0011; step(2);
        chk("R7 output ignored", flags[2], 0);
        port_hi = 4'b1011; step(1);
        chk("R7 input line", flags[2], 1);
    endtask

    initial begin
        step(3);
        rst = 0;
        step(1);
        t_reset();
        t_pulses();
        t_handshake();
        t_ext();
        t_port();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule